// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and an asynchronous static RAM of 128K bytes. It turns single-byte read and write requests into strobe sequences on the memory pins. The memory is selected by a pair of chip selects with opposite polarity, written with a low-going write strobe and read with a low-going output enable. Each phase of an access lasts a whole number of clock cycles. That count is the ceiling of the memory's minimum time for the phase divided by the clock period parameter, and never less than one cycle.

On the host side the request channel is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold its request, and any request shown then is not taken. `req_ready` stays low from the accepting edge until the access has fully ended, including the bus turnaround that follows a read. Read data returns on a one-cycle `resp_valid` pulse. This channel has no back-pressure, so the host must take the data in that cycle.

The memory data bus is split into output, input and drive-enable signals. The controller drives the bus only while the write strobe is low. It keeps the output enable high for the whole write, so the bus never has two drivers.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset the memory is deselected and nothing drives the bus: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `resp_valid`=0, and `req_ready`=1.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. A request shown while `req_ready` is low has no effect. With a 10 ns clock, `req_ready` stays low for 8 cycles after a write is accepted and for 10 cycles after a read is accepted.
- R3: The chip selects always move as a pair. During every access phase except the read turnaround, `mem_cs1_n`=0 and `mem_cs2`=1. In idle and in the turnaround, `mem_cs1_n`=1 and `mem_cs2`=0.
- R4: In a write, the selection lasts at least 70 ns and the write strobe is low for at least 55 ns. The address is valid no later than the strobe's falling edge and does not change while the memory is selected.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low. Write data is driven for at least 30 ns before the strobe rises, and `mem_oe_n` stays high for the whole write.
- R6: In a read, `mem_we_n`=1 and `mem_oe_n`=0 with the chip selects active for ceil(70 ns / period) cycles, which is 7 cycles at a 10 ns clock. The bus is sampled on the last of these cycles. `resp_valid` pulses for exactly one cycle, 7 cycles after the accepting edge.
- R7: After a read, the output enable stays high for at least ceil(25 ns / period) cycles before the controller can enable its bus drivers again.
- R8: A read returns the byte most recently written to that 17-bit address, including addresses 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | One-cycle read data strobe |
| resp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
A read's data is due on `resp_valid` 7 cycles after the accepting edge. `req_ready` is due back 8 cycles after a write is accepted and 10 cycles after a read. The scoreboard records a timestamp when each request is driven and checks the measured latency and busy length on falling edges, where the outputs are stable. The memory model in the bench works in nanoseconds. It keeps returning corrupted data until 70 ns after the output enable falls. It also flags any strobe width, data setup, cycle length or turnaround time that falls short of the minimums, so a shortened phase shows up as wrong data or as a timing failure.

// File: rtl/sram_timing_pkg.sv
`timescale 1ns/1ps
package sram_timing_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSETUP  = 3'd1,
    PH_WPULSE  = 3'd2,
    PH_WRECOV  = 3'd3,
    PH_RACCESS = 3'd4,
    PH_RTURN   = 3'd5
  } phase_e;

  // ceiling of ns / period, with a floor of one cycle
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_timing_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 6,
  parameter int RECOV_CYC = 1,
  parameter int ACC_CYC   = 7,
  parameter int TURN_CYC  = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   at_end
);

  localparam int MAXC  = imax(imax(imax(SETUP_CYC, PULSE_CYC), imax(RECOV_CYC, ACC_CYC)), TURN_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] L_RECOV = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] L_ACC   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] L_TURN  = CNT_W'(TURN_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign at_end = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = start_wr ? PH_WSETUP : PH_RACCESS;
        cnt_d   = start_wr ? L_SETUP : L_ACC;
      end
    end else if (!at_end) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (phase_q)
        PH_WSETUP:  begin phase_d = PH_WPULSE; cnt_d = L_PULSE; end
        PH_WPULSE:  begin phase_d = PH_WRECOV; cnt_d = L_RECOV; end
        PH_RACCESS: begin phase_d = PH_RTURN;  cnt_d = L_TURN;  end
        default:    begin phase_d = PH_IDLE;   cnt_d = '0;      end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: the idle state never carries a pending count
  a_r2_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> at_end);

  // R6: a read access always ends in the turnaround phase
  a_r6_access_to_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RACCESS && at_end) |=> (phase_q == PH_RTURN));

endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
module sram_pin_drive
  import sram_timing_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_d,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe
);

  logic sel_d;
  assign sel_d = (phase_d == PH_WSETUP) || (phase_d == PH_WPULSE) ||
                 (phase_d == PH_WRECOV) || (phase_d == PH_RACCESS);

  // every memory pin leaves a flop: no decode glitches on the strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs1_n <= !sel_d;
      mem_cs2   <= sel_d;
      mem_we_n  <= (phase_d != PH_WPULSE);
      mem_oe_n  <= (phase_d != PH_RACCESS);
      mem_dq_oe <= (phase_d == PH_WPULSE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (load) begin
      mem_addr   <= addr_in;
      mem_dq_out <= wdata_in;
    end
  end

  // R4: the address does not move while the memory stays selected
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

  // R5: write data does not move while it is driven
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/sram_rd_latch.sv
`timescale 1ns/1ps
module sram_rd_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= take;
      if (take) rdata <= dq_in;
    end
  end

  // R6: the response strobe is a single-cycle pulse
  a_r6_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_timing_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int T_CYCLE_NS  = 70,
  parameter int T_WPULSE_NS = 55,
  parameter int T_DSETUP_NS = 30,
  parameter int T_ASETUP_NS = 0,
  parameter int T_WRECOV_NS = 0,
  parameter int T_ACCESS_NS = 70,
  parameter int T_OEACC_NS  = 35,
  parameter int T_OFF_NS    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int SETUP_CYC = ns2cyc(T_ASETUP_NS, CLK_NS);
  localparam int RECOV_CYC = ns2cyc(T_WRECOV_NS, CLK_NS);
  // the strobe is stretched so that setup + pulse + recovery meet the cycle minimum
  localparam int PULSE_CYC = imax(imax(ns2cyc(T_WPULSE_NS, CLK_NS), ns2cyc(T_DSETUP_NS, CLK_NS)),
                                  ns2cyc(T_CYCLE_NS, CLK_NS) - SETUP_CYC - RECOV_CYC);
  localparam int ACC_CYC   = imax(imax(ns2cyc(T_ACCESS_NS, CLK_NS), ns2cyc(T_OEACC_NS, CLK_NS)),
                                  ns2cyc(T_CYCLE_NS, CLK_NS));
  localparam int TURN_CYC  = ns2cyc(T_OFF_NS, CLK_NS);

  phase_e phase_q, phase_d;
  logic   at_end;
  logic   accept;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  sram_seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC),
    .ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .phase_q(phase_q), .phase_d(phase_d), .at_end(at_end)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .load(accept),
    .addr_in(req_addr), .wdata_in(req_wdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
  );

  sram_rd_latch #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .take(phase_q == PH_RACCESS && at_end),
    .dq_in(mem_dq_in), .rdata(resp_rdata), .rvalid(resp_valid)
  );

  // R2: an accepted request drops ready on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3: the two chip selects always agree
  a_r3_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs1_n == !mem_cs2);

  // R5: the bus is driven only inside the write strobe, never with output enable low
  a_r5_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  // R4: the write strobe only falls while selected
  a_r4_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2));

  // R6: a response only follows a cycle with output enable low
  a_r6_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(!mem_oe_n));

endmodule

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;

  localparam int PER     = 10;
  localparam int ACC     = (70 + PER - 1) / PER;            // read access cycles
  localparam int TURN    = (25 + PER - 1) / PER;            // turnaround cycles
  localparam int WR_BUSY = 1 + 6 + 1;                       // setup, pulse, recovery
  localparam int RD_BUSY = ACC + TURN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        resp_valid;
  logic [7:0]  resp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  sram_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0] model_mem [int];
  logic       sel;
  assign sel = !mem_cs1_n && mem_cs2;
  time t_sel = 0, t_we_fall = 0, t_drive = 0, t_addr = 0, t_oe_rise = 0;
  bit  seen_read = 0, wr_cycle = 0, rd_ok = 0;
  logic [7:0] rd_byte = 8'h00;
  int  contention = 0;

  assign mem_dq_in = rd_ok ? rd_byte : ~rd_byte;

  always @(posedge sel) begin t_sel = $time; wr_cycle = 0; end
  always @(mem_addr) t_addr = $time;

  always @(negedge sel)
    if (wr_cycle) chk(($time - t_sel) >= 70, "R4", "write select ns", $time - t_sel, 70);
    else          chk(($time - t_sel) >= 70, "R6", "read select ns", $time - t_sel, 70);

  always @(negedge mem_we_n) begin
    t_we_fall = $time;
    chk(sel, "R3", "selected at strobe fall", sel, 1);
    chk(mem_oe_n == 1'b1, "R5", "oe high in write", mem_oe_n, 1);
  end

  always @(posedge mem_dq_oe) begin
    t_drive = $time;
    if (seen_read) chk(($time - t_oe_rise) >= 25, "R7", "turnaround ns", $time - t_oe_rise, 25);
  end

  always @(posedge mem_we_n) if (sel) begin
    chk(($time - t_we_fall) >= 55, "R4", "strobe width ns", $time - t_we_fall, 55);
    chk(($time - t_drive) >= 30, "R5", "data setup ns", $time - t_drive, 30);
    chk(t_addr <= t_we_fall, "R4", "addr before strobe", t_addr, t_we_fall);
    model_mem[int'(mem_addr)] = mem_dq_out;
    wr_cycle = 1;
  end

  always @(negedge mem_oe_n) begin
    rd_ok = 0;
    #1;
    chk(sel && mem_we_n, "R6", "read strobes", {sel, mem_we_n}, 3);
    rd_byte = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
    #68;
    if (!mem_oe_n && sel) rd_ok = 1;
  end

  always @(posedge mem_oe_n) begin rd_ok = 0; t_oe_rise = $time; seen_read = 1; end

  always @(negedge clk) if (mem_dq_oe && !mem_oe_n && sel) contention++;

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] data; time t0; } rd_item_t;
  rd_item_t    rd_q[$];
  int          busy_q[$];
  logic [7:0]  shadow [int];
  int          busy_n = 0;
  bit          prev_rv = 0;

  task automatic access(input bit wr, input int addr, input logic [7:0] d);
    rd_item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 17'(addr); req_wdata = d;
    if (wr) begin
      shadow[addr] = d;
      busy_q.push_back(WR_BUSY);
    end else begin
      it.data = shadow.exists(addr) ? shadow[addr] : 8'h00;
      it.t0   = $time;
      rd_q.push_back(it);
      busy_q.push_back(RD_BUSY);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (resp_valid) begin
      rd_item_t e;
      chk(!prev_rv, "R6", "resp pulse one cycle", prev_rv, 0);
      if (rd_q.size() == 0) chk(0, "R6", "unexpected resp", 1, 0);
      else begin
        e = rd_q.pop_front();
        chk(resp_rdata == e.data, "R8", "read data", resp_rdata, e.data);
        chk(($time - e.t0) / PER == ACC + 1, "R6", "read latency", ($time - e.t0) / PER, ACC + 1);
      end
    end
    prev_rv = resp_valid;
    if (!req_ready) busy_n++;
    else if (busy_n != 0) begin
      int exp_b;
      exp_b = (busy_q.size() != 0) ? busy_q.pop_front() : -1;
      chk(busy_n == exp_b, "R2", "ready low cycles", busy_n, exp_b);
      busy_n = 0;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * PER);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      done = 1;
      finish_run();
    end
  end

  initial begin
    int pool[12];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1", "pins in reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !resp_valid, "R1", "ready/resp in reset", {req_ready, resp_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_cs1_n && !mem_cs2, "R1", "idle after reset", {req_ready, mem_cs1_n, mem_cs2}, 3'b110);

    // R8: lowest and highest address
    access(1, 0, 8'h11);
    access(1, 17'h1FFFF, 8'hEE);
    access(0, 0, 8'h00);
    access(0, 17'h1FFFF, 8'h00);

    // R7: read directly followed by a write
    access(0, 0, 8'h00);
    access(1, 17'h00100, 8'h3C);
    access(0, 17'h00100, 8'h00);

    // R2: request held while busy is ignored
    access(1, 17'h0ABCD, 8'h5A);
    req_valid = 1; req_write = 1; req_addr = 17'h0ABCD; req_wdata = 8'hC3;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R2", "still busy while held", req_ready, 0);
    req_valid = 0;
    access(0, 17'h0ABCD, 8'h00);

    // R8: random mix over a pool of addresses
    foreach (pool[i]) pool[i] = int'($urandom_range(17'h1FFFF, 0));
    for (int n = 0; n < 80; n++) begin
      int a;
      a = pool[$urandom_range(11, 0)];
      if ($urandom_range(1, 0) == 1) access(1, a, 8'($urandom));
      else                           access(0, a, 8'h00);
    end

    repeat (20) @(negedge clk);
    chk(rd_q.size() == 0, "R6", "all reads answered", rd_q.size(), 0);
    chk(busy_q.size() == 0, "R2", "all busy windows seen", busy_q.size(), 0);
    chk(contention == 0, "R5", "bus contention cycles", contention, 0);
    chk(mem_cs1_n && !mem_cs2 && !mem_dq_oe, "R3", "deselected when idle",
        {mem_cs1_n, mem_cs2, mem_dq_oe}, 3'b100);
    done = 1;
    finish_run();
  end

endmodule